// File: doc/BRIEF.md
# Double-Buffered USB IN Endpoint Controller

This block holds the transmit payload for a single USB IN endpoint in two banks of byte storage. Firmware fills one bank while the USB serial engine drains the other, so the next packet can be staged while the current one is on the wire. Firmware appends bytes to whichever bank it currently owns. It then hands that bank over with a ready strobe, and its own pointer moves on to the other bank.

On the USB side, the serial engine presents an IN token strobe. It then pulls bytes with a read strobe and reports the host handshake with an ACK strobe. The controller answers each token with either a data indication or a NAK indication one cycle later. Banks are transmitted in strict alternation. A packet that is not acknowledged is sent again from its first byte when the next token arrives. An acknowledged packet frees its bank and raises a sticky completion flag, which also drives the interrupt request.

Top module: `usb_in_pingpong_ep`

## Requirements
- R1: After a synchronous reset, both banks are empty and not ready, `cpu_bank` and `usb_bank` are 0, and `tx_comp`, `irq`, `wr_err`, `resp_data` and `resp_nak` are all 0.
- R2: Each accepted `cpu_wr` stores `cpu_wdata` at the next byte position of the bank that `cpu_bank` names and raises that bank's count by one. `tx_len` shows the count of the bank that `usb_bank` names.
- R3: `cpu_set_rdy` on an empty bank sets that bank's bit in `bank_rdy` (bit 0 for bank 0, bit 1 for bank 1) and toggles `cpu_bank` on the next clock.
- R4: An IN token while the bank named by `usb_bank` holds a ready or already-sent payload gives a one-cycle `resp_data` pulse on the next clock. The same edge clears that bank's `bank_rdy` bit and rewinds the read position to byte 0.
- R5: An IN token while the bank named by `usb_bank` is empty gives a one-cycle `resp_nak` pulse on the next clock. It changes no bank state.
- R6: `tx_byte` shows the byte at the current read position of the bank being sent. Each `usb_rd` advances that position by one.
- R7: `usb_ack` while the current USB bank has been sent empties that bank, clears its count, toggles `usb_bank` and sets `tx_comp`. Banks are therefore sent in the order 0, 1, 0, 1.
- R8: `tx_comp` stays set until `cpu_clr_comp`. A new ACK in the same cycle as the clear keeps it set.
- R9: `irq` is asserted exactly while `tx_comp` is set.
- R10: A token that arrives before the ACK of the previous packet resends the same bank from byte 0. `usb_bank` does not change and `tx_comp` is not set.
- R11: `cpu_wr` or `cpu_set_rdy` while the bank named by `cpu_bank` is ready or being sent is ignored and sets the sticky `wr_err` flag. `cpu_clr_err` clears that flag.
- R12: A bank holds at most MAX_PKT bytes (64 by default). A write to a full bank is ignored and sets `wr_err`.
- R13: Firmware writes to one bank and USB reads from the other bank may happen in the same cycle without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr | input | 1 | Append `cpu_wdata` to the firmware bank |
| cpu_wdata | input | 8 | Payload byte from firmware |
| cpu_set_rdy | input | 1 | Mark the firmware bank ready and move to the other bank |
| cpu_clr_comp | input | 1 | Clear the transmit-complete flag |
| cpu_clr_err | input | 1 | Clear the write-error flag |
| usb_in_tok | input | 1 | IN token received from the host |
| usb_rd | input | 1 | Serial engine consumed `tx_byte` |
| usb_ack | input | 1 | Host acknowledged the data packet |
| cpu_bank | output | 1 | Bank that firmware currently loads |
| usb_bank | output | 1 | Bank that the USB side sends next |
| bank_rdy | output | 2 | Per-bank ready flags |
| wr_err | output | 1 | Sticky flag for a rejected firmware access |
| tx_comp | output | 1 | Sticky transmit-complete flag |
| irq | output | 1 | Interrupt request to firmware |
| resp_data | output | 1 | Token is answered with data |
| resp_nak | output | 1 | Token is answered with NAK |
| tx_len | output | $clog2(MAX_PKT+1) | Byte count of the USB bank |
| tx_byte | output | 8 | Byte at the current read position |

## Verification
The hardest state to reach is the one where both banks are locked at once: one waits for an ACK, the other is ready, and firmware still tries to write. The stimulus gets there by staging bank 1 during the first transfer, then filling and readying bank 0 before the token that starts bank 1. Only then does it write. A second hard case is a token that arrives with no ACK since the previous packet, which is what the resend path needs. The stimulus holds back the ACK, issues a second token, and reads the first byte again. A behavioural model of the banks with integer counts, built in the bench, is compared with every output on every clock.

// File: rtl/usb_in_pingpong_ep.sv
module usb_in_pingpong_ep #(
  parameter int MAX_PKT = 64,
  localparam int AW = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1,
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_wr,
  input  logic [7:0]    cpu_wdata,
  input  logic          cpu_set_rdy,
  input  logic          cpu_clr_comp,
  input  logic          cpu_clr_err,
  input  logic          usb_in_tok,
  input  logic          usb_rd,
  input  logic          usb_ack,
  output logic          cpu_bank,
  output logic          usb_bank,
  output logic [1:0]    bank_rdy,
  output logic          wr_err,
  output logic          tx_comp,
  output logic          irq,
  output logic          resp_data,
  output logic          resp_nak,
  output logic [CW-1:0] tx_len,
  output logic [7:0]    tx_byte
);
  localparam logic [1:0]    S_EMPTY = 2'd0, S_READY = 2'd1, S_SENT = 2'd2;
  localparam logic [CW-1:0] FULL    = CW'(MAX_PKT);

  logic [7:0]    mem [2][MAX_PKT];
  logic [1:0]    st  [2];
  logic [CW-1:0] cnt [2];
  logic [CW-1:0] rd;

  wire cpu_open = (st[cpu_bank] == S_EMPTY);
  wire wr_ok    = cpu_wr && cpu_open && (cnt[cpu_bank] != FULL);
  wire rdy_ok   = cpu_set_rdy && cpu_open;
  wire err_ev   = (cpu_wr && !wr_ok) || (cpu_set_rdy && !cpu_open);
  wire has_pkt  = (st[usb_bank] != S_EMPTY);
  wire send     = usb_in_tok && has_pkt;
  wire ack_ok   = usb_ack && (st[usb_bank] == S_SENT);

  assign bank_rdy = {st[1] == S_READY, st[0] == S_READY};
  assign irq      = tx_comp;
  assign tx_len   = cnt[usb_bank];
  assign tx_byte  = mem[usb_bank][rd[AW-1:0]];

  always_ff @(posedge clk)
    if (wr_ok) mem[cpu_bank][cnt[cpu_bank][AW-1:0]] <= cpu_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st[0]     <= S_EMPTY;
      st[1]     <= S_EMPTY;
      cnt[0]    <= '0;
      cnt[1]    <= '0;
      cpu_bank  <= 1'b0;
      usb_bank  <= 1'b0;
      rd        <= '0;
      resp_data <= 1'b0;
      resp_nak  <= 1'b0;
      tx_comp   <= 1'b0;
      wr_err    <= 1'b0;
    end else begin
      resp_data <= send;
      resp_nak  <= usb_in_tok && !has_pkt;
      tx_comp   <= ack_ok || (tx_comp && !cpu_clr_comp);
      wr_err    <= err_ev || (wr_err && !cpu_clr_err);
      if (wr_ok) cnt[cpu_bank] <= cnt[cpu_bank] + 1'b1;
      if (rdy_ok) begin
        st[cpu_bank] <= S_READY;
        cpu_bank     <= ~cpu_bank;
      end
      if (send) begin
        st[usb_bank] <= S_SENT;
        rd           <= '0;
      end else if (usb_rd && rd != FULL) begin
        rd <= rd + 1'b1;
      end
      if (ack_ok) begin
        st[usb_bank]  <= S_EMPTY;
        cnt[usb_bank] <= '0;
        usb_bank      <= ~usb_bank;
      end
    end
  end
endmodule

// File: rtl/usb_in_pingpong_ep_chk.sv
module usb_in_pingpong_ep_chk #(
  parameter int MAX_PKT = 64,
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          usb_ack,
  input logic          cpu_clr_comp,
  input logic          cpu_clr_err,
  input logic          usb_bank,
  input logic          resp_data,
  input logic          resp_nak,
  input logic          tx_comp,
  input logic          irq,
  input logic          wr_err,
  input logic [CW-1:0] tx_len
);
  a_r4_one_answer: assert property (@(posedge clk) disable iff (rst)
    !(resp_data && resp_nak));

  a_r5_nak_keeps_bank: assert property (@(posedge clk) disable iff (rst)
    (resp_nak && !$past(usb_ack)) |-> (usb_bank == $past(usb_bank)));

  a_r7_swap_flags: assert property (@(posedge clk) disable iff (rst)
    (usb_bank != $past(usb_bank)) |-> tx_comp);

  a_r8_comp_sticky: assert property (@(posedge clk) disable iff (rst)
    (tx_comp && !cpu_clr_comp) |=> tx_comp);

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(usb_ack));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (wr_err && !cpu_clr_err) |=> wr_err);

  a_r12_len_bound: assert property (@(posedge clk) disable iff (rst)
    tx_len <= CW'(MAX_PKT));
endmodule

bind usb_in_pingpong_ep usb_in_pingpong_ep_chk #(.MAX_PKT(MAX_PKT)) u_chk (
  .clk(clk), .rst(rst), .usb_ack(usb_ack), .cpu_clr_comp(cpu_clr_comp),
  .cpu_clr_err(cpu_clr_err), .usb_bank(usb_bank), .resp_data(resp_data),
  .resp_nak(resp_nak), .tx_comp(tx_comp), .irq(irq), .wr_err(wr_err),
  .tx_len(tx_len)
);

// File: tb/tb_usb_in_pingpong_ep.sv
module tb_usb_in_pingpong_ep;
  localparam int MP = 64;
  localparam int CW = $clog2(MP + 1);

  logic clk = 0, rst = 1;
  logic cpu_wr = 0, cpu_set_rdy = 0, cpu_clr_comp = 0, cpu_clr_err = 0;
  logic usb_in_tok = 0, usb_rd = 0, usb_ack = 0;
  logic [7:0] cpu_wdata = 0;
  logic cpu_bank, usb_bank, wr_err, tx_comp, irq, resp_data, resp_nak;
  logic [1:0] bank_rdy;
  logic [CW-1:0] tx_len;
  logic [7:0] tx_byte;

  int total = 0, fails = 0, cycles = 0;

  usb_in_pingpong_ep #(.MAX_PKT(MP)) dut (.*);

  always #4 clk = ~clk;

  // behavioural reference: bank state 0 empty, 1 ready, 2 sent
  int ms[2], mc[2], mcp, mup, mrd;
  logic [7:0] mm[2][MP];
  bit mcomp, merr, mdat, mnak;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit open, has, wok, rok, aok, eev;
    int ocp, oup;
    cycles++;
    if (rst) begin
      ms[0] = 0; ms[1] = 0; mc[0] = 0; mc[1] = 0;
      mcp = 0; mup = 0; mrd = 0;
      mcomp = 0; merr = 0; mdat = 0; mnak = 0;
    end else begin
      ocp = mcp; oup = mup;
      open = (ms[ocp] == 0);
      has = (ms[oup] != 0);
      wok = cpu_wr && open && mc[ocp] < MP;
      rok = cpu_set_rdy && open;
      aok = usb_ack && ms[oup] == 2;
      eev = (cpu_wr && !wok) || (cpu_set_rdy && !open);
      mdat = usb_in_tok && has;
      mnak = usb_in_tok && !has;
      if (wok) begin mm[ocp][mc[ocp]] = cpu_wdata; mc[ocp]++; end
      if (rok) begin ms[ocp] = 1; mcp = 1 - ocp; end
      if (usb_in_tok && has) begin ms[oup] = 2; mrd = 0; end
      else if (usb_rd && mrd < MP) mrd++;
      if (aok) begin ms[oup] = 0; mc[oup] = 0; mup = 1 - oup; end
      mcomp = aok || (mcomp && !cpu_clr_comp);
      merr = eev || (merr && !cpu_clr_err);
      #2;
      check(cpu_bank == mcp, "R3", "cpu_bank", cpu_bank, mcp);
      check(usb_bank == mup, "R7", "usb_bank", usb_bank, mup);
      check(bank_rdy == {ms[1] == 1, ms[0] == 1}, "R4", "bank_rdy",
            bank_rdy, {ms[1] == 1, ms[0] == 1});
      check(tx_len == mc[mup], "R2", "tx_len", tx_len, mc[mup]);
      check(resp_data == mdat, "R4", "resp_data", resp_data, mdat);
      check(resp_nak == mnak, "R5", "resp_nak", resp_nak, mnak);
      check(tx_comp == mcomp, "R8", "tx_comp", tx_comp, mcomp);
      check(irq == mcomp, "R9", "irq", irq, mcomp);
      check(wr_err == merr, "R11", "wr_err", wr_err, merr);
      if (ms[mup] == 2 && mrd < mc[mup])
        check(tx_byte == mm[mup][mrd], "R6", "tx_byte", tx_byte, mm[mup][mrd]);
    end
  end

  task automatic cyc(input bit wr, input logic [7:0] d, input bit rdy,
                     input bit tok, input bit rd, input bit ack,
                     input bit clrc = 0, input bit clre = 0);
    cpu_wr = wr; cpu_wdata = d; cpu_set_rdy = rdy; usb_in_tok = tok;
    usb_rd = rd; usb_ack = ack; cpu_clr_comp = clrc; cpu_clr_err = clre;
    @(posedge clk); #3;
    cpu_wr = 0; cpu_set_rdy = 0; usb_in_tok = 0; usb_rd = 0; usb_ack = 0;
    cpu_clr_comp = 0; cpu_clr_err = 0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #2;
    check(bank_rdy == 0 && !cpu_bank && !usb_bank, "R1", "banks", bank_rdy, 0);
    check(!tx_comp && !irq && !wr_err && !resp_data && !resp_nak, "R1", "flags",
          {tx_comp, irq, wr_err, resp_data, resp_nak}, 0);

    cyc(0, 0, 0, 1, 0, 0);
    check(resp_nak && !resp_data, "R5", "nak on empty", resp_nak, 1);

    for (int i = 0; i < 4; i++) cyc(1, 8'hA0 + 8'(i), 0, 0, 0, 0);
    check(tx_len == 4, "R2", "count", tx_len, 4);
    cyc(0, 0, 1, 0, 0, 0);
    check(cpu_bank == 1 && bank_rdy == 2'b01, "R3", "handover", bank_rdy, 1);

    cyc(1, 8'hB0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    check(resp_data && bank_rdy == 2'b00, "R4", "take bank", bank_rdy, 0);
    check(tx_byte == 8'hA0, "R6", "first byte", tx_byte, 8'hA0);
    for (int i = 1; i < 4; i++) begin
      cyc(1, 8'hB0 + 8'(i), 0, 0, 1, 0);
      check(tx_byte == 8'hA0 + 8'(i), "R13", "read during write", tx_byte, 8'hA0 + i);
    end

    cyc(0, 0, 0, 1, 0, 0);
    check(resp_data && tx_byte == 8'hA0, "R10", "resend byte", tx_byte, 8'hA0);
    check(!usb_bank && !tx_comp, "R10", "no swap", {usb_bank, tx_comp}, 0);

    cyc(0, 0, 0, 0, 0, 1);
    check(tx_comp && usb_bank && tx_len == 4, "R7", "ack swap", tx_len, 4);
    check(irq, "R9", "irq on", irq, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    check(!tx_comp && !irq, "R8", "cleared", {tx_comp, irq}, 0);

    cyc(0, 0, 1, 0, 0, 0);
    cyc(1, 8'hC0, 0, 0, 0, 0);
    cyc(1, 8'hC1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    check(bank_rdy == 2'b11 && cpu_bank == 1, "R3", "both ready", bank_rdy, 3);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(1, 8'hD0, 0, 0, 0, 0);
    check(wr_err, "R11", "locked write", wr_err, 1);
    cyc(0, 0, 1, 0, 0, 0);
    check(cpu_bank == 1 && wr_err, "R11", "locked ready", cpu_bank, 1);
    repeat (3) cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 1);
    check(tx_comp, "R8", "ack beats clear", tx_comp, 1);
    check(tx_len == 2 && !usb_bank, "R11", "bank0 untouched", tx_len, 2);
    cyc(0, 0, 0, 1, 0, 0);
    check(tx_byte == 8'hC0, "R7", "alternation", tx_byte, 8'hC0);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 1);
    check(!wr_err && !tx_comp, "R11", "err cleared", wr_err, 0);

    for (int i = 0; i < MP; i++) cyc(1, 8'(i), 0, 0, 0, 0);
    check(!wr_err, "R12", "full no err", wr_err, 0);
    cyc(1, 8'hEE, 0, 0, 0, 0);
    check(wr_err, "R12", "overflow err", wr_err, 1);
    cyc(0, 0, 1, 0, 0, 0);
    check(tx_len == MP, "R12", "count capped", tx_len, MP);
    cyc(0, 0, 0, 1, 0, 0);
    repeat (MP - 1) cyc(0, 0, 0, 0, 1, 0);
    check(tx_byte == 8'(MP - 1), "R12", "last byte", tx_byte, MP - 1);
    cyc(0, 0, 0, 0, 0, 1);
    repeat (2) cyc(0, 0, 0, 0, 0, 0);
    finish_run();
  end

  initial begin
    wait (cycles > 20000);
    total++; fails++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    finish_run();
  end
endmodule